// File: doc/BRIEF.md
# SPI Slave with Memory DMA

This block is a serial peripheral slave that moves complete messages between an SPI link and a local byte memory with no per-byte work from a processor. Software places the outgoing bytes in a transmit region, then arms the block with a byte count and the base addresses of a transmit region and a receive region. When the external master pulls its select line low, the block shifts the stored bytes out and stores every byte it receives into the receive region.

A message ends in one of two ways. It can end when the programmed count is reached, which suits fixed-length use. It can also end earlier, when the master releases select, which suits variable-length use. Both endings raise a done interrupt, and a length output reports how many bytes arrived. Clocking past the count while select stays low raises an overflow interrupt. A received byte that cannot be written to memory in time raises an overrun interrupt. On its core side the block has a single memory port that uses a request/grant handshake.

Top module: `spi_dma_slave`

## Requirements
- R1: After reset, `busy`, `mem_req`, all three interrupt outputs and `rx_len` are 0.
- R2: The link runs in SPI mode 0 with the MSB first. The block samples MOSI on rising SCK and changes MISO after falling SCK. Byte i of a message, counting from 0, is the memory byte at `tx_base + i`.
- R3: Byte i received on MOSI, counting from 0, is written to memory address `rx_base + i`. No other memory write happens.
- R4: When `count` bytes have been received and all of their writes have been granted, `irq_done` pulses high for exactly one cycle and `rx_len` equals `count`.
- R5: If select rises before `count` bytes arrive, the message ends. `irq_done` pulses once, `rx_len` holds the number of whole bytes received, and `irq_ovf` stays low.
- R6: After the count is reached, the first rising SCK edge while select is still low pulses `irq_ovf` once. Bytes beyond the count are never written to memory.
- R7: Received bytes wait in a write slot and then in the memory port. If a byte completes while the slot is still occupied, `irq_ovr` pulses and that byte is dropped, which leaves no write at its address.
- R8: Once `mem_req` is high, it stays high with `mem_addr`, `mem_we` and `mem_wdata` stable until the cycle in which `mem_gnt` is high. Read data is taken in that same grant cycle.
- R9: `miso_oe` is 1 while `nss_n` is low and 0 while `nss_n` is high.
- R10: The next transmit byte is fetched as soon as the current byte starts shifting. With a grant delay of 8 cycles and a gap of one SCK period between bytes, every transmitted byte is still correct.
- R11: `cfg_start` is acted on only while `busy` is low. A pulse during a message changes neither its count nor its addresses. Each new message starts at the base addresses and uses the current memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_start | input | 1 | One-cycle pulse that arms a message |
| cfg_count | input | CW | Number of bytes in the message |
| cfg_tx_base | input | AW | Base address of the transmit region |
| cfg_rx_base | input | AW | Base address of the receive region |
| busy | output | 1 | Block is armed, in a message, or has a memory access outstanding |
| rx_len | output | CW | Bytes received in the current or last message |
| irq_done | output | 1 | One-cycle pulse when a message is complete |
| irq_ovf | output | 1 | One-cycle pulse when the master clocks past the count |
| irq_ovr | output | 1 | One-cycle pulse when a received byte is dropped |
| sck | input | 1 | Serial clock from the master |
| nss_n | input | 1 | Active-low select from the master |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for miso |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_gnt | input | 1 | Grant; the access completes in this cycle |
| mem_rdata | input | 8 | Read data, valid while granted |

## Verification
The bench delays grants by 8 cycles while the master keeps its minimum byte gap. A design that fetched the next transmit byte late would send zeros or shifted data in that case. It also stalls grants for hundreds of cycles, so that a receive byte arrives with both the slot and the port full. A design with wrong overrun handling would either write a stale byte or overwrite the pending one, and the bench's write scoreboard catches both errors. Other tests end a message early by raising select, and clock a byte past the count. These show whether the block confuses the done and overflow cases, or writes data beyond the count. A final test sends an arm pulse in the middle of a message and rewrites the transmit region between messages. This exposes a design that latches its configuration at the wrong time or keeps its pointers from the previous message.

// File: rtl/spi_dma_slave.sv
module spi_dma_slave #(
  parameter int AW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_start,
  input  logic [CW-1:0] cfg_count,
  input  logic [AW-1:0] cfg_tx_base,
  input  logic [AW-1:0] cfg_rx_base,
  output logic          busy,
  output logic [CW-1:0] rx_len,
  output logic          irq_done,
  output logic          irq_ovf,
  output logic          irq_ovr,
  input  logic          sck,
  input  logic          nss_n,
  input  logic          mosi,
  output logic          miso,
  output logic          miso_oe,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic          mem_gnt,
  input  logic [7:0]    mem_rdata
);

  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_RUN, S_TAIL} state_t;

  state_t        st;
  logic [2:0]    sck_s, nss_s;
  logic [1:0]    mosi_s;
  logic [CW-1:0] cnt_q, tx_fi, rx_cnt;
  logic [AW-1:0] txb_q, rxb_q, wr_addr;
  logic [2:0]    bitcnt;
  logic [6:0]    rx_sh;
  logic [7:0]    tx_sh, tx_nx, wr_data;
  logic          tx_v, wr_pend, ovf_seen;

  logic sck_rise, sck_fall, nss_fall, nss_hi, shifting;
  logic byte_done, wr_busy, finish, arm, wr_issue, tx_issue, rd_gnt, pend_free, tx_load;

  assign sck_rise  = sck_s[1] & ~sck_s[2];
  assign sck_fall  = ~sck_s[1] & sck_s[2];
  assign nss_fall  = ~nss_s[1] & nss_s[2];
  assign nss_hi    = nss_s[1];
  assign shifting  = (st == S_RUN) || (st == S_TAIL);
  assign byte_done = (st == S_RUN) && sck_rise && (bitcnt == 3'd7);
  assign wr_busy   = wr_pend | (mem_req & mem_we);
  assign finish    = (st == S_RUN) && ((rx_cnt == cnt_q) || nss_hi) && !wr_busy;
  assign arm       = cfg_start && (st == S_IDLE) && !mem_req;
  assign wr_issue  = !mem_req && wr_pend;
  assign tx_issue  = !mem_req && !wr_pend && (st != S_IDLE) && !tx_v && (tx_fi < cnt_q);
  assign rd_gnt    = mem_req & mem_gnt & ~mem_we;
  assign pend_free = !wr_pend || wr_issue;
  assign tx_load   = shifting && sck_fall && (bitcnt == 3'd0);

  assign busy    = (st != S_IDLE) | mem_req;
  assign rx_len  = rx_cnt;
  assign miso    = tx_sh[7];
  assign miso_oe = ~nss_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      sck_s     <= 3'b000;
      nss_s     <= 3'b111;
      mosi_s    <= 2'b00;
      cnt_q     <= '0;
      tx_fi     <= '0;
      rx_cnt    <= '0;
      txb_q     <= '0;
      rxb_q     <= '0;
      wr_addr   <= '0;
      bitcnt    <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      tx_nx     <= '0;
      wr_data   <= '0;
      tx_v      <= 1'b0;
      wr_pend   <= 1'b0;
      ovf_seen  <= 1'b0;
      irq_done  <= 1'b0;
      irq_ovf   <= 1'b0;
      irq_ovr   <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      sck_s    <= {sck_s[1:0], sck};
      nss_s    <= {nss_s[1:0], nss_n};
      mosi_s   <= {mosi_s[0], mosi};
      irq_done <= 1'b0;
      irq_ovf  <= 1'b0;
      irq_ovr  <= 1'b0;

      if (wr_issue) begin
        mem_req   <= 1'b1;
        mem_we    <= 1'b1;
        mem_addr  <= wr_addr;
        mem_wdata <= wr_data;
        wr_pend   <= 1'b0;
      end else if (tx_issue) begin
        mem_req  <= 1'b1;
        mem_we   <= 1'b0;
        mem_addr <= txb_q + AW'(tx_fi);
        tx_fi    <= tx_fi + 1'b1;
      end else if (mem_req && mem_gnt) begin
        mem_req <= 1'b0;
      end

      if (rd_gnt && !tx_load) begin
        tx_nx <= mem_rdata;
        tx_v  <= 1'b1;
      end

      if (shifting && sck_rise) begin
        bitcnt <= bitcnt + 1'b1;
        rx_sh  <= {rx_sh[5:0], mosi_s[1]};
      end
      if (shifting && sck_fall) begin
        if (bitcnt == 3'd0) begin
          tx_sh <= tx_v ? tx_nx : (rd_gnt ? mem_rdata : 8'h00);
          tx_v  <= 1'b0;
        end else begin
          tx_sh <= {tx_sh[6:0], 1'b0};
        end
      end

      if (byte_done) begin
        rx_cnt <= rx_cnt + 1'b1;
        if (pend_free) begin
          wr_pend <= 1'b1;
          wr_data <= {rx_sh, mosi_s[1]};
          wr_addr <= rxb_q + AW'(rx_cnt);
        end else begin
          irq_ovr <= 1'b1;
        end
      end

      case (st)
        S_IDLE: if (arm) begin
          st    <= S_ARMED;
          cnt_q <= cfg_count;
          txb_q <= cfg_tx_base;
          rxb_q <= cfg_rx_base;
          tx_fi <= '0;
          tx_v  <= 1'b0;
        end
        S_ARMED: if (nss_fall) begin
          st     <= S_RUN;
          bitcnt <= '0;
          rx_cnt <= '0;
          tx_sh  <= tx_nx;
          tx_v   <= 1'b0;
        end
        S_RUN: if (finish) begin
          irq_done <= 1'b1;
          ovf_seen <= 1'b0;
          st       <= nss_hi ? S_IDLE : S_TAIL;
        end
        S_TAIL: begin
          if (sck_rise && !ovf_seen) begin
            irq_ovf  <= 1'b1;
            ovf_seen <= 1'b1;
          end
          if (nss_hi) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_dma_slave_chk.sv
module spi_dma_slave_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_gnt,
  input logic [AW-1:0] mem_addr,
  input logic [7:0]    mem_wdata,
  input logic          irq_done,
  input logic          irq_ovf,
  input logic          irq_ovr
);

  // R8
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R4
  done_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |-> !(mem_req && mem_we));

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |=> !irq_done);

  // R6
  ovf_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ovf |=> !irq_ovf);

  // R6
  ovf_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ovf |-> !irq_done);

  // R7
  ovr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ovr |=> !irq_ovr);

endmodule

bind spi_dma_slave spi_dma_slave_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we), .mem_gnt(mem_gnt),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .irq_done(irq_done), .irq_ovf(irq_ovf),
  .irq_ovr(irq_ovr)
);

// File: tb/sim_spi_dma_slave.sv
module sim_spi_dma_slave;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_start = 1'b0;
  logic [7:0] cfg_count = '0, cfg_tx_base = '0, cfg_rx_base = '0;
  logic busy, irq_done, irq_ovf, irq_ovr, miso, miso_oe;
  logic [7:0] rx_len;
  logic sck = 1'b0, nss_n = 1'b1, mosi = 1'b0;
  logic mem_req, mem_we, mem_gnt;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;

  always #4 clk = ~clk;

  spi_dma_slave u0 (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_count(cfg_count),
    .cfg_tx_base(cfg_tx_base), .cfg_rx_base(cfg_rx_base), .busy(busy), .rx_len(rx_len),
    .irq_done(irq_done), .irq_ovf(irq_ovf), .irq_ovr(irq_ovr), .sck(sck), .nss_n(nss_n),
    .mosi(mosi), .miso(miso), .miso_oe(miso_oe), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
  );

  int n_chk = 0, n_err = 0;
  int c_done = 0, c_ovf = 0, c_ovr = 0, s_done, s_ovf, s_ovr;
  int gdly = 0, wcnt = 0;
  logic [7:0] mem [256];
  logic [15:0] exp_wr [$];

  assign mem_rdata = mem[mem_addr];

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // memory model with grant delay, write scoreboard and interrupt counters
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_gnt <= 1'b0;
      wcnt    <= 0;
    end else begin
      if (mem_req && !mem_gnt) begin
        if (wcnt >= gdly) begin mem_gnt <= 1'b1; wcnt <= 0; end
        else wcnt <= wcnt + 1;
      end else mem_gnt <= 1'b0;
      if (mem_req && mem_gnt && mem_we) begin
        if (exp_wr.size() == 0) chk(1'b0, "R3 unexpected write addr", int'(mem_addr), -1);
        else begin
          logic [15:0] e;
          e = exp_wr.pop_front();
          chk({mem_addr, mem_wdata} == e, "R3 write {addr,data}", int'({mem_addr, mem_wdata}), int'(e));
        end
      end
      if (irq_done) c_done <= c_done + 1;
      if (irq_ovf)  c_ovf  <= c_ovf + 1;
      if (irq_ovr)  c_ovr  <= c_ovr + 1;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_byte(input logic [7:0] d, output logic [7:0] q);
    for (int i = 7; i >= 0; i--) begin
      mosi = d[i];
      cyc(5);
      sck = 1'b1;
      q[i] = miso;
      cyc(5);
      sck = 1'b0;
    end
    cyc(10);
  endtask

  task automatic msg(input int cnt, input int nsent, input int txb, input int rxb,
                     input int nwr, input bit chk_tx, input bit poke, input string tag);
    logic [7:0] d, q;
    while (busy) cyc(1);
    cfg_count = 8'(cnt); cfg_tx_base = 8'(txb); cfg_rx_base = 8'(rxb);
    cfg_start = 1'b1; cyc(1); cfg_start = 1'b0;
    cyc(20);
    s_done = c_done; s_ovf = c_ovf; s_ovr = c_ovr;
    nss_n = 1'b0;
    cyc(10);
    chk(miso_oe == 1'b1, {tag, " R9 oe while selected"}, int'(miso_oe), 1);
    for (int i = 0; i < nsent; i++) begin
      d = 8'(i * 37 + cnt * 11 + 5);
      if (i < nwr) exp_wr.push_back({8'(rxb + i), d});
      spi_byte(d, q);
      if (chk_tx && i < cnt)
        chk(q == mem[8'(txb + i)], {tag, " R2 miso byte"}, int'(q), int'(mem[8'(txb + i)]));
      if (poke && i == 0) begin
        cfg_count = 8'd1; cfg_tx_base = 8'h00; cfg_start = 1'b1; cyc(1); cfg_start = 1'b0;
      end
    end
    cyc(30);
    nss_n = 1'b1;
    cyc(30);
    chk(miso_oe == 1'b0, {tag, " R9 oe released"}, int'(miso_oe), 0);
    while (busy) cyc(1);
    cyc(4);
    chk(exp_wr.size() == 0, {tag, " R3 writes outstanding"}, exp_wr.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    cyc(5);
    rst_n = 1'b1;
    cyc(2);
    // R1 reset state
    chk(busy == 1'b0 && mem_req == 1'b0, "R1 busy/mem_req", int'({busy, mem_req}), 0);
    chk({irq_done, irq_ovf, irq_ovr} == 3'b000, "R1 irqs", int'({irq_done, irq_ovf, irq_ovr}), 0);
    chk(rx_len == 8'd0, "R1 rx_len", int'(rx_len), 0);
    chk(miso_oe == 1'b0, "R9 oe at reset", int'(miso_oe), 0);

    // R4 fixed length
    msg(4, 4, 8'h10, 8'h80, 4, 1'b1, 1'b0, "T1");
    chk(c_done - s_done == 1, "R4 done count", c_done - s_done, 1);
    chk(rx_len == 8'd4, "R4 rx_len", int'(rx_len), 4);
    chk(c_ovf - s_ovf == 0, "R4 no ovf", c_ovf - s_ovf, 0);

    // R10 delayed grants
    gdly = 8;
    msg(5, 5, 8'h30, 8'h90, 5, 1'b1, 1'b0, "T2 R10");
    chk(c_done - s_done == 1, "R10 done count", c_done - s_done, 1);
    chk(c_ovr - s_ovr == 0, "R10 no overrun", c_ovr - s_ovr, 0);
    gdly = 0;

    // R5 variable length
    msg(8, 3, 8'h40, 8'hA0, 3, 1'b1, 1'b0, "T3");
    chk(c_done - s_done == 1, "R5 done count", c_done - s_done, 1);
    chk(rx_len == 8'd3, "R5 rx_len", int'(rx_len), 3);
    chk(c_ovf - s_ovf == 0, "R5 no ovf", c_ovf - s_ovf, 0);

    // R6 overflow
    msg(2, 3, 8'h50, 8'hB0, 2, 1'b1, 1'b0, "T4");
    chk(c_ovf - s_ovf == 1, "R6 ovf count", c_ovf - s_ovf, 1);
    chk(c_done - s_done == 1, "R6 done count", c_done - s_done, 1);
    chk(rx_len == 8'd2, "R6 rx_len", int'(rx_len), 2);

    // R7 overrun: prefetch done at arm, then grants stall
    fork
      begin cyc(22); gdly = 250; end
    join_none
    msg(2, 2, 8'h60, 8'hC0, 1, 1'b0, 1'b0, "T5");
    chk(c_ovr - s_ovr == 1, "R7 overrun count", c_ovr - s_ovr, 1);
    chk(c_done - s_done == 1, "R7 done count", c_done - s_done, 1);
    gdly = 0;

    // R11 re-arm with new content, arm pulse during message ignored
    for (int i = 0; i < 3; i++) mem[8'h10 + i] = 8'(8'hC5 ^ (i * 29));
    msg(3, 3, 8'h10, 8'hD0, 3, 1'b1, 1'b1, "T6 R11");
    chk(rx_len == 8'd3, "R11 rx_len", int'(rx_len), 3);
    chk(c_done - s_done == 1, "R11 done count", c_done - s_done, 1);
    chk(c_ovf - s_ovf == 0, "R11 no ovf", c_ovf - s_ovf, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule